// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog that raises a system reset request unless software proves it is alive. Software does this by writing two key bytes, in order, to one service register on a simple register write bus. The first key (0x55) arms the mechanism. The second key (0xAA), written while armed, returns the timeout counter to zero. A single write of either key on its own never restarts the count, so a runaway loop that keeps writing one value cannot keep the system alive.

The timeout counter advances once per clock cycle while the enable input is high. It stands still while enable is low, and it stands still when the clock stops. If the counter reaches its terminal value before a complete arm/clear pair arrives, the block drives a registered reset request for a fixed number of cycles. It then starts over from a zero count, disarmed. Bus writes of other data, and writes to other addresses, may sit between the two keys. The service register holds no readable state.

The write port has no back-pressure: every strobed write is taken in the cycle it is presented, and there is no ready signal. Enable and the reset request are plain level signals.

Top module: `kseq_watchdog`

## Requirements
- R1: While and after reset, `rst_req` is 0, the count is zero and the block is disarmed.
- R2: With `en` held high and no service, `rst_req` rises after exactly TIMEOUT enabled clock edges counted from zero.
- R3: Writing 0x55 to the service address (SVC_ADDR) arms the block but does not restart the count.
- R4: Writing 0xAA to SVC_ADDR while armed sets the count to zero, so the next timeout comes TIMEOUT enabled edges after that write. This also applies when the write lands on the terminal cycle: the clear wins and no reset request is raised.
- R5: Writing 0xAA to SVC_ADDR while disarmed has no effect on the count.
- R6: Between the arm and the clear, writes of other data to SVC_ADDR and writes of any data to other addresses leave the block armed.
- R7: A successful clear also disarms the block, so a later 0xAA needs a new 0x55 first.
- R8: `rst_req` stays high for exactly HOLD consecutive cycles and then falls. The count is then zero and the block is disarmed.
- R9: While `en` is low, the count does not advance.
- R10: `rd_data` reads as zero in every bit for the service address and for every other address.
- R11: Service writes made while `rst_req` is high have no effect, including 0x55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the count advances only on its edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable; the counter freezes while low |
| wr_en | input | 1 | Write strobe, taken in the cycle it is high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data; always zero |
| rst_req | output | 1 | Registered system reset request, high for HOLD cycles |

## Verification
On every cycle, the checker confirms four things. The reset request rises only after exactly TIMEOUT enabled edges since the last restart. It lasts exactly HOLD cycles. An arm key, or a clear key written while disarmed, leaves the count advancing normally. A clear key written while armed zeroes the count and disarms the block. Only the bench's scenarios can show the port-level outcomes: that filler writes between the keys keep the arm, that a clear on the terminal cycle avoids a reset, that a key written during a reset request is forgotten afterwards, and that reads return zero. The bench checks each of these against a behavioural model on every clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Classification of one bus write as seen by the service logic.
  typedef enum logic [1:0] {
    KEY_NONE  = 2'd0,  // no write, or a write to another address
    KEY_ARM   = 2'd1,  // arming key written to the service register
    KEY_CLEAR = 2'd2,  // clearing key written to the service register
    KEY_OTHER = 2'd3   // any other value written to the service register
  } key_e;

endpackage

// File: rtl/wdg_key_decode.sv
module wdg_key_decode
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = ADDR_W'(8'h3A),
  parameter logic [DATA_W-1:0] ARM_KEY  = DATA_W'(8'h55),
  parameter logic [DATA_W-1:0] CLR_KEY  = DATA_W'(8'hAA)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output key_e              kind
);

  logic hit;

  assign hit = wr_en && (wr_addr == SVC_ADDR);

  always_comb begin
    if (!hit)                    kind = KEY_NONE;
    else if (wr_data == ARM_KEY) kind = KEY_ARM;
    else if (wr_data == CLR_KEY) kind = KEY_CLEAR;
    else                         kind = KEY_OTHER;
  end

endmodule

// File: rtl/wdg_arm_state.sv
module wdg_arm_state
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  key_e kind,
  input  logic busy,
  output logic armed,
  output logic clear_evt
);

  // A clear is honoured only while armed and outside a reset request.
  assign clear_evt = !busy && armed && (kind == KEY_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (busy) begin
      armed <= 1'b0;
    end else if (kind == KEY_ARM) begin
      armed <= 1'b1;
    end else if (clear_evt) begin
      armed <= 1'b0;
    end
  end

endmodule

// File: rtl/wdg_timeout_ctr.sv
module wdg_timeout_ctr #(
  parameter int unsigned TIMEOUT = 4096,
  localparam int unsigned CNT_W  = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             busy,
  input  logic             clear_evt,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic at_last;

  assign at_last = (cnt == LAST);
  // A clear arriving on the terminal cycle takes priority over expiry.
  assign expire  = en && !busy && !clear_evt && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (busy || clear_evt || expire) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdg_reset_hold.sv
module wdg_reset_hold #(
  parameter int unsigned HOLD = 4,
  localparam int unsigned HOLD_W = (HOLD > 2) ? $clog2(HOLD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  output logic rst_req
);

  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD - 1);

  logic [HOLD_W-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      hcnt    <= '0;
    end else if (rst_req) begin
      if (hcnt == HOLD_LAST) begin
        rst_req <= 1'b0;
        hcnt    <= '0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end else if (expire) begin
      rst_req <= 1'b1;
      hcnt    <= '0;
    end
  end

endmodule

// File: rtl/kseq_watchdog.sv
module kseq_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = ADDR_W'(8'h3A),
  parameter logic [DATA_W-1:0] ARM_KEY  = DATA_W'(8'h55),
  parameter logic [DATA_W-1:0] CLR_KEY  = DATA_W'(8'hAA),
  parameter int unsigned TIMEOUT  = 4096,
  parameter int unsigned HOLD     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req
);

  localparam int unsigned CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  key_e             key_kind;
  logic             armed;
  logic             clear_evt;
  logic             expire;
  logic [CNT_W-1:0] ctr_val;

  // The service register keeps no readable state; every read is zero.
  assign rd_data = {DATA_W{1'b0}} & {DATA_W{rd_addr == SVC_ADDR}};

  wdg_key_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SVC_ADDR(SVC_ADDR),
    .ARM_KEY (ARM_KEY),
    .CLR_KEY (CLR_KEY)
  ) u_decode (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .kind   (key_kind)
  );

  wdg_arm_state u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (key_kind),
    .busy     (rst_req),
    .armed    (armed),
    .clear_evt(clear_evt)
  );

  wdg_timeout_ctr #(
    .TIMEOUT(TIMEOUT)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .busy     (rst_req),
    .clear_evt(clear_evt),
    .expire   (expire),
    .cnt      (ctr_val)
  );

  wdg_reset_hold #(
    .HOLD(HOLD)
  ) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .rst_req(rst_req)
  );

endmodule

// File: rtl/wdg_watch_chk.sv
module wdg_watch_chk
  import wdg_pkg::*;
#(
  parameter int unsigned TIMEOUT = 4096,
  parameter int unsigned HOLD    = 4,
  parameter int unsigned CNT_W   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             rst_req,
  input logic             armed,
  input key_e             key_kind,
  input logic [CNT_W-1:0] ctr_val
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  // Independent window counters, kept here instead of deep $past chains.
  int unsigned en_run;
  int unsigned req_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_run  <= 0;
      req_run <= 0;
    end else begin
      if (rst_req || (key_kind == KEY_CLEAR && armed)) en_run <= 0;
      else if (en) en_run <= en_run + 1;
      req_run <= rst_req ? req_run + 1 : 0;
    end
  end

  a_r2_timeout_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (en_run == TIMEOUT));

  a_r2_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req |-> (en_run < TIMEOUT));

  a_r8_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (req_run < HOLD));

  a_r8_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (req_run == HOLD && ctr_val == '0 && !armed));

  a_r3_arm_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (key_kind == KEY_ARM && !rst_req && ctr_val != LAST)
      |=> (ctr_val == $past(ctr_val) + CNT_W'($past(en))));

  a_r5_clear_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (key_kind == KEY_CLEAR && !armed && !rst_req && ctr_val != LAST)
      |=> (ctr_val == $past(ctr_val) + CNT_W'($past(en))));

  a_r4_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (key_kind == KEY_CLEAR && armed && !rst_req) |=> (ctr_val == '0 && !rst_req));

  a_r7_clear_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (key_kind == KEY_CLEAR && armed && !rst_req) |=> !armed);

  a_r6_filler_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ((key_kind == KEY_NONE || key_kind == KEY_OTHER) && armed && !rst_req) |=> armed);

  a_r11_busy_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !armed);

endmodule

bind kseq_watchdog wdg_watch_chk #(
  .TIMEOUT(TIMEOUT),
  .HOLD   (HOLD),
  .CNT_W  (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .rst_req (rst_req),
  .armed   (armed),
  .key_kind(key_kind),
  .ctr_val (ctr_val)
);

// File: tb/test_kseq_watchdog.sv
module test_kseq_watchdog;

  localparam int CLK_PERIOD = 10;
  localparam int TO   = 20;
  localparam int HLD  = 4;
  localparam logic [7:0] SVC   = 8'h3A;
  localparam logic [7:0] OTHER = 8'h10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rst_req;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  // Behavioural reference model.
  int m_cnt, m_hold;
  bit m_armed, m_rst;

  kseq_watchdog #(.TIMEOUT(TO), .HOLD(HLD)) i_kseq_watchdog (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_armed = 0; m_rst = 0;
    end else if (m_rst) begin
      m_hold = m_hold + 1;
      if (m_hold == HLD) begin
        m_rst = 0; m_cnt = 0; m_armed = 0;
      end
    end else begin
      bit svc, clr;
      svc = wr_en && (wr_addr == SVC);
      clr = svc && (wr_data == 8'hAA) && m_armed;
      if (svc && wr_data == 8'h55) m_armed = 1;
      else if (clr) m_armed = 0;
      if (clr) m_cnt = 0;
      else if (en) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == TO) begin
          m_rst = 1; m_hold = 0; m_cnt = 0;
        end
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " model"}, {7'd0, rst_req}, {7'd0, m_rst});
      chk("R10 read", rd_data, 8'h00);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 req in reset", {7'd0, rst_req}, 8'h00);
    rst_n = 1'b1;
    step(1);
    chk("R1 req after reset", {7'd0, rst_req}, 8'h00);
    rd_addr = SVC;
    chk("R10 svc read", rd_data, 8'h00);

    phase = "R9";
    step(30);
    chk("R9 idle while disabled", {7'd0, rst_req}, 8'h00);

    phase = "R2"; en = 1'b1;
    step(TO-1); chk("R2 before timeout", {7'd0, rst_req}, 8'h00);
    step(1);    chk("R2 at timeout", {7'd0, rst_req}, 8'h01);
    phase = "R8";
    step(HLD-1); chk("R8 still held", {7'd0, rst_req}, 8'h01);
    step(1);     chk("R8 released", {7'd0, rst_req}, 8'h00);

    phase = "R3";
    step(5); wr(SVC, 8'h55); step(TO-7);
    chk("R3 arm alone no restart", {7'd0, rst_req}, 8'h00);
    step(1); chk("R3 timeout kept", {7'd0, rst_req}, 8'h01);
    step(HLD);

    phase = "R4";
    step(10); wr(SVC, 8'h55); wr(SVC, 8'hAA);
    step(TO-1); chk("R4 restarted", {7'd0, rst_req}, 8'h00);
    step(1);    chk("R4 timeout after clear", {7'd0, rst_req}, 8'h01);
    step(HLD);

    phase = "R5";
    step(10); wr(SVC, 8'hAA); step(TO-12);
    chk("R5 unarmed clear ignored", {7'd0, rst_req}, 8'h00);
    step(1); chk("R5 timeout kept", {7'd0, rst_req}, 8'h01);
    step(HLD);

    phase = "R6";
    rd_addr = OTHER;
    step(2); wr(SVC, 8'h55); wr(SVC, 8'h12); wr(OTHER, 8'hAA); wr(SVC, 8'h00);
    wr(SVC, 8'hAA);
    step(TO-1); chk("R6 arm survived filler", {7'd0, rst_req}, 8'h00);
    step(1);    chk("R6 timeout after clear", {7'd0, rst_req}, 8'h01);
    step(HLD);
    chk("R10 other read", rd_data, 8'h00);

    phase = "R7";
    wr(SVC, 8'h55); wr(SVC, 8'hAA); step(5); wr(SVC, 8'hAA); step(TO-7);
    chk("R7 second clear ignored", {7'd0, rst_req}, 8'h00);
    step(1); chk("R7 timeout", {7'd0, rst_req}, 8'h01);

    phase = "R11";
    wr(SVC, 8'h55); step(HLD-2);
    chk("R11 req held", {7'd0, rst_req}, 8'h01);
    step(1); chk("R11 req dropped", {7'd0, rst_req}, 8'h00);
    wr(SVC, 8'hAA); step(TO-2);
    chk("R11 arm during req forgotten", {7'd0, rst_req}, 8'h00);
    step(1); chk("R11 timeout", {7'd0, rst_req}, 8'h01);
    step(HLD);

    phase = "R4";
    step(10); wr(SVC, 8'h55); step(TO-12); wr(SVC, 8'hAA);
    chk("R4 clear on terminal cycle", {7'd0, rst_req}, 8'h00);
    step(TO-1); chk("R4 restarted from terminal", {7'd0, rst_req}, 8'h00);
    step(1);    chk("R4 timeout", {7'd0, rst_req}, 8'h01);
    step(HLD);

    phase = "R9";
    step(10); en = 1'b0; step(25);
    chk("R9 frozen", {7'd0, rst_req}, 8'h00);
    en = 1'b1; step(TO-11);
    chk("R9 resumed", {7'd0, rst_req}, 8'h00);
    step(1); chk("R9 timeout", {7'd0, rst_req}, 8'h01);
    step(HLD + 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule